// File: doc/BRIEF.md
# Parallel ADC Conversion Sequencer

This block runs the host side of the handshake with a 16-bit sampling converter that has a parallel output bus. A one-cycle start strobe makes it pull the select line low and pulse the conversion-start line low for a set number of clocks. It then waits for the converter's active-low busy line to rise again. Next it pulls the read line low and waits a set number of settle clocks. On the last of those clocks it latches the data bus and presents the word with a single-cycle valid pulse.

The same block also manages the converter's power-down line. It has two low-power states. A light one keeps select low while power-down is held low. A deep one raises select while power-down is held low. Only a wake command leaves either state. A watchdog counter guards the wait for busy, and two sticky flags report a lost end of conversion and any ignored start request. Each conversion takes a few dozen clocks, well under 500 clocks at 250 MHz, so the sequencer sustains a 500 kHz sample rate.

Top module: `adc_seq_ctrl`

## Requirements
- R1: While reset is high and on the first cycle after it, `cs_n_o`, `convst_n_o`, `rd_n_o` and `shdn_n_o` are 1, and `valid_o`, `timeout_o` and `overrun_o` are 0.
- R2: A start strobe sampled in the idle state drives `cs_n_o` and `convst_n_o` low from the next clock edge. `convst_n_o` stays low for exactly PULSE_CYC cycles, and it is never low while `cs_n_o` is high.
- R3: Busy is synchronised through two flops. `rd_n_o` goes low on the third rising clock edge after `busy_n_i` goes from 0 to 1, and stays low for exactly SETTLE_CYC cycles. `cs_n_o` is low during that time, and read and conversion-start are never low together.
- R4: The data bus is sampled on the last read cycle. In the cycle after `rd_n_o` returns high, `valid_o` is 1 for exactly one cycle and `data_o` holds the sampled word (bit 15 is the MSB).
- R5: If busy does not rise within TIMEOUT_CYC cycles after `convst_n_o` returns high, the sequencer returns to idle with `cs_n_o`, `convst_n_o` and `rd_n_o` all 1. `timeout_o` goes to 1 in the same cycle and stays 1 until reset. Later conversions still complete.
- R6: A start strobe that arrives while a conversion or read is in progress launches no second conversion and produces no extra valid pulse, and it sets the sticky `overrun_o`.
- R7: A nap command in idle (when no start is present) drives `shdn_n_o` low and keeps `cs_n_o` low, with `convst_n_o` and `rd_n_o` high.
- R8: A sleep command in idle (when neither start nor nap is present) drives `shdn_n_o` low with `cs_n_o` high.
- R9: In either low-power state a start strobe produces no conversion-start pulse and sets `overrun_o`.
- R10: A wake command in a low-power state returns `shdn_n_o` and `cs_n_o` to 1 from the next edge, and a following start runs a normal conversion.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst | input | 1 | Synchronous reset, active high |
| start_i | input | 1 | Conversion request strobe |
| nap_i | input | 1 | Command to enter the light low-power state |
| sleep_i | input | 1 | Command to enter the deep low-power state |
| wake_i | input | 1 | Command to leave a low-power state |
| busy_n_i | input | 1 | Converter busy, low during conversion (asynchronous) |
| data_i | input | DATA_W | Converter parallel data bus |
| cs_n_o | output | 1 | Converter select, active low |
| convst_n_o | output | 1 | Conversion start, active low |
| rd_n_o | output | 1 | Read enable, active low |
| shdn_n_o | output | 1 | Power-down, active low |
| data_o | output | DATA_W | Captured conversion word |
| valid_o | output | 1 | One-cycle pulse marking a new word on data_o |
| timeout_o | output | 1 | Sticky flag: busy never ended a conversion |
| overrun_o | output | 1 | Sticky flag: a start request was ignored |

## Verification
The bench drives inputs on the falling clock edge and samples on the falling edge too, so every count below is a number of whole clocks. Conversion-start must be seen low on the first sample after the start strobe and must stay low for PULSE_CYC samples. Read must first be seen low on the third sample after busy is raised, and must stay low for SETTLE_CYC samples. The valid pulse and its data are checked on the first sample where read is high again, and checked absent on the next sample. For the timeout, the flag must be clear on the sample numbered TIMEOUT_CYC after conversion-start rises and set on the one that follows. The low-power states and wake are checked one sample after their command.

// File: rtl/adc_seq_pkg.sv
package adc_seq_pkg;

    typedef enum logic [2:0] {
        ST_IDLE,
        ST_START,
        ST_WAIT,
        ST_READ,
        ST_NAP,
        ST_SLEEP
    } seq_state_e;

    typedef struct packed {
        logic cs_n;
        logic convst_n;
        logic rd_n;
        logic shdn_n;
    } pin_set_t;

    function automatic pin_set_t pins_for(seq_state_e s);
        pin_set_t p;
        p = '{cs_n: 1'b1, convst_n: 1'b1, rd_n: 1'b1, shdn_n: 1'b1};
        case (s)
            ST_START: begin p.cs_n = 1'b0; p.convst_n = 1'b0; end
            ST_WAIT:  p.cs_n = 1'b0;
            ST_READ:  begin p.cs_n = 1'b0; p.rd_n = 1'b0; end
            ST_NAP:   begin p.cs_n = 1'b0; p.shdn_n = 1'b0; end
            ST_SLEEP: p.shdn_n = 1'b0;
            default:  ;
        endcase
        return p;
    endfunction

    function automatic int max3(int a, int b, int c);
        int m;
        m = (a > b) ? a : b;
        return (m > c) ? m : c;
    endfunction

endpackage

// File: rtl/adc_busy_sync.sv
module adc_busy_sync #(
    parameter int STAGES = 2
) (
    input  logic clk,
    input  logic rst,
    input  logic busy_n_async,
    output logic done_rise
);
    logic [STAGES-1:0] chain;
    logic              prev;

    generate
        if (STAGES == 1) begin : g_single
            always_ff @(posedge clk) begin
                if (rst) chain <= '1;
                else     chain <= busy_n_async;
            end
        end else begin : g_multi
            always_ff @(posedge clk) begin
                if (rst) chain <= '1;
                else     chain <= {chain[STAGES-2:0], busy_n_async};
            end
        end
    endgenerate

    always_ff @(posedge clk) begin
        if (rst) prev <= 1'b1;
        else     prev <= chain[STAGES-1];
    end

    assign done_rise = chain[STAGES-1] & ~prev;

    a_r3_rise_single: assert property (@(posedge clk) disable iff (rst)
        done_rise |=> !done_rise);

endmodule

// File: rtl/adc_step_timer.sv
module adc_step_timer #(
    parameter int WIDTH = 8
) (
    input  logic             clk,
    input  logic             rst,
    input  logic             load,
    input  logic [WIDTH-1:0] load_val,
    output logic             expired
);
    logic [WIDTH-1:0] cnt;

    always_ff @(posedge clk) begin
        if (rst)              cnt <= '0;
        else if (load)        cnt <= load_val;
        else if (cnt != '0)   cnt <= cnt - 1'b1;
    end

    assign expired = (cnt == '0);

    a_r2_timer_holds_floor: assert property (@(posedge clk) disable iff (rst)
        (!load && expired) |=> expired);

endmodule

// File: rtl/adc_seq_ctrl.sv
module adc_seq_ctrl
    import adc_seq_pkg::*;
#(
    parameter int DATA_W      = 16,
    parameter int PULSE_CYC   = 4,
    parameter int SETTLE_CYC  = 3,
    parameter int TIMEOUT_CYC = 1000,
    parameter int SYNC_STAGES = 2
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              start_i,
    input  logic              nap_i,
    input  logic              sleep_i,
    input  logic              wake_i,
    input  logic              busy_n_i,
    input  logic [DATA_W-1:0] data_i,
    output logic              cs_n_o,
    output logic              convst_n_o,
    output logic              rd_n_o,
    output logic              shdn_n_o,
    output logic [DATA_W-1:0] data_o,
    output logic              valid_o,
    output logic              timeout_o,
    output logic              overrun_o
);
    localparam int CNT_MAX = max3(PULSE_CYC, SETTLE_CYC, TIMEOUT_CYC);
    localparam int CNT_W   = $clog2(CNT_MAX + 1);
    localparam logic [CNT_W-1:0] LD_PULSE  = CNT_W'(PULSE_CYC - 1);
    localparam logic [CNT_W-1:0] LD_SETTLE = CNT_W'(SETTLE_CYC - 1);
    localparam logic [CNT_W-1:0] LD_TMO    = CNT_W'(TIMEOUT_CYC - 1);

    seq_state_e       state;
    pin_set_t         pins;
    logic             busy_done;
    logic             t_expired;
    logic             t_load;
    logic [CNT_W-1:0] t_val;

    adc_busy_sync #(.STAGES(SYNC_STAGES)) u_sync (
        .clk          (clk),
        .rst          (rst),
        .busy_n_async (busy_n_i),
        .done_rise    (busy_done)
    );

    adc_step_timer #(.WIDTH(CNT_W)) u_timer (
        .clk      (clk),
        .rst      (rst),
        .load     (t_load),
        .load_val (t_val),
        .expired  (t_expired)
    );

    always_comb begin
        t_load = 1'b0;
        t_val  = LD_PULSE;
        case (state)
            ST_IDLE:  if (start_i) begin t_load = 1'b1; t_val = LD_PULSE; end
            ST_START: if (t_expired) begin t_load = 1'b1; t_val = LD_TMO; end
            ST_WAIT:  if (busy_done) begin t_load = 1'b1; t_val = LD_SETTLE; end
            default:  ;
        endcase
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            state     <= ST_IDLE;
            data_o    <= '0;
            valid_o   <= 1'b0;
            timeout_o <= 1'b0;
            overrun_o <= 1'b0;
        end else begin
            valid_o <= 1'b0;
            if (start_i && state != ST_IDLE) overrun_o <= 1'b1;
            case (state)
                ST_IDLE: begin
                    if (start_i)      state <= ST_START;
                    else if (nap_i)   state <= ST_NAP;
                    else if (sleep_i) state <= ST_SLEEP;
                end
                ST_START: if (t_expired) state <= ST_WAIT;
                ST_WAIT: begin
                    if (busy_done) begin
                        state <= ST_READ;
                    end else if (t_expired) begin
                        state     <= ST_IDLE;
                        timeout_o <= 1'b1;
                    end
                end
                ST_READ: begin
                    if (t_expired) begin
                        data_o  <= data_i;
                        valid_o <= 1'b1;
                        state   <= ST_IDLE;
                    end
                end
                ST_NAP, ST_SLEEP: if (wake_i) state <= ST_IDLE;
                default: state <= ST_IDLE;
            endcase
        end
    end

    assign pins       = pins_for(state);
    assign cs_n_o     = pins.cs_n;
    assign convst_n_o = pins.convst_n;
    assign rd_n_o     = pins.rd_n;
    assign shdn_n_o   = pins.shdn_n;

    a_r2_start_under_select: assert property (@(posedge clk) disable iff (rst)
        !convst_n_o |-> !cs_n_o);
    a_r3_read_under_select: assert property (@(posedge clk) disable iff (rst)
        !rd_n_o |-> !cs_n_o);
    a_r3_no_overlap: assert property (@(posedge clk) disable iff (rst)
        !(!rd_n_o && !convst_n_o));
    a_r4_valid_single: assert property (@(posedge clk) disable iff (rst)
        valid_o |=> !valid_o);
    a_r4_valid_after_read: assert property (@(posedge clk) disable iff (rst)
        valid_o |-> $past(!rd_n_o));
    a_r5_timeout_sticky: assert property (@(posedge clk) disable iff (rst)
        timeout_o |=> timeout_o);
    a_r5_timeout_released: assert property (@(posedge clk) disable iff (rst)
        $rose(timeout_o) |-> (cs_n_o && convst_n_o && rd_n_o));
    a_r6_overrun_sticky: assert property (@(posedge clk) disable iff (rst)
        overrun_o |=> overrun_o);
    a_r9_lowpower_quiet: assert property (@(posedge clk) disable iff (rst)
        !shdn_n_o |-> (convst_n_o && rd_n_o));

endmodule

// File: tb/test_adc_seq_ctrl.sv
`timescale 1ns/1ps
module test_adc_seq_ctrl;
    localparam int PULSE  = 4;
    localparam int SETTLE = 3;
    localparam int TMO    = 40;

    logic        clk = 1'b0;
    logic        rst = 1'b1;
    logic        start = 1'b0, nap = 1'b0, sleep = 1'b0, wake = 1'b0;
    logic        busy_n = 1'b1;
    logic [15:0] bus_word = 16'h0000;
    logic [15:0] data_bus;
    logic        cs_n, convst_n, rd_n, shdn_n, valid, tmo_flag, ovr_flag;
    logic [15:0] data_out;
    int          n_cmp = 0;
    int          n_bad = 0;

    always #2 clk = ~clk;

    assign data_bus = (!cs_n && !rd_n) ? bus_word : 16'h0000;

    adc_seq_ctrl #(
        .DATA_W(16), .PULSE_CYC(PULSE), .SETTLE_CYC(SETTLE), .TIMEOUT_CYC(TMO), .SYNC_STAGES(2)
    ) i_adc_seq_ctrl (
        .clk(clk), .rst(rst), .start_i(start), .nap_i(nap), .sleep_i(sleep), .wake_i(wake),
        .busy_n_i(busy_n), .data_i(data_bus), .cs_n_o(cs_n), .convst_n_o(convst_n),
        .rd_n_o(rd_n), .shdn_n_o(shdn_n), .data_o(data_out), .valid_o(valid),
        .timeout_o(tmo_flag), .overrun_o(ovr_flag)
    );

    task automatic chk(input string req, input string what, input int act, input int exp);
        n_cmp++;
        if (act != exp) begin
            n_bad++;
            $display("FAIL %s %s: actual=%0d expected=%0d", req, what, act, exp);
        end
    endtask

    task automatic pulse_cmd(ref logic sig);
        @(negedge clk) sig = 1'b1;
        @(negedge clk) sig = 1'b0;
    endtask

    task automatic do_conversion(input logic [15:0] word, input int conv_len, input bit poke);
        int k;
        pulse_cmd(start);
        chk("R2", "cs_n at start", cs_n, 0);
        chk("R2", "convst_n at start", convst_n, 0);
        k = 0;
        while (convst_n == 1'b0 && k < 100) begin
            if (cs_n != 1'b0) chk("R2", "cs_n during convst", cs_n, 0);
            k++;
            @(negedge clk);
        end
        chk("R2", "convst low width", k, PULSE);
        busy_n = 1'b0;
        for (int i = 0; i < conv_len; i++) begin
            @(negedge clk);
            start = poke && (i == 1);
            if (i == conv_len - 1) chk("R3", "cs_n while waiting", cs_n, 0);
        end
        start = 1'b0;
        busy_n = 1'b1;
        bus_word = word;
        k = 0;
        while (rd_n == 1'b1 && k < 100) begin
            @(negedge clk);
            k++;
        end
        chk("R3", "busy rise to read", k, 3);
        k = 0;
        while (rd_n == 1'b0 && k < 100) begin
            if (cs_n != 1'b0) chk("R3", "cs_n during read", cs_n, 0);
            k++;
            @(negedge clk);
        end
        chk("R3", "read low width", k, SETTLE);
        chk("R4", "valid after read", valid, 1);
        chk("R4", "captured word", data_out, word);
        @(negedge clk);
        chk("R4", "valid one cycle", valid, 0);
        if (poke) begin
            chk("R6", "overrun flag", ovr_flag, 1);
            for (int i = 0; i < 6; i++) begin
                if (convst_n != 1'b1 || valid != 1'b0) begin
                    chk("R6", "second conversion started", 1, 0);
                end
                @(negedge clk);
            end
            chk("R6", "no extra convst", convst_n, 1);
        end
    endtask

    task automatic test_reset;
        chk("R1", "cs_n", cs_n, 1);
        chk("R1", "convst_n", convst_n, 1);
        chk("R1", "rd_n", rd_n, 1);
        chk("R1", "shdn_n", shdn_n, 1);
        chk("R1", "valid", valid, 0);
        chk("R1", "timeout", tmo_flag, 0);
        chk("R1", "overrun", ovr_flag, 0);
    endtask

    task automatic test_nap;
        pulse_cmd(nap);
        chk("R7", "nap shdn_n", shdn_n, 0);
        chk("R7", "nap cs_n", cs_n, 0);
        chk("R7", "nap convst_n", convst_n, 1);
        chk("R9", "overrun before", ovr_flag, 0);
        pulse_cmd(start);
        for (int i = 0; i < 5; i++) begin
            if (convst_n != 1'b1) chk("R9", "convst in nap", convst_n, 1);
            @(negedge clk);
        end
        chk("R9", "overrun after nap start", ovr_flag, 1);
        chk("R9", "still in nap", shdn_n, 0);
        pulse_cmd(wake);
        chk("R10", "wake shdn_n", shdn_n, 1);
        chk("R10", "wake cs_n", cs_n, 1);
        do_conversion(16'h8001, 5, 1'b0);
    endtask

    task automatic test_sleep;
        pulse_cmd(sleep);
        chk("R8", "sleep shdn_n", shdn_n, 0);
        chk("R8", "sleep cs_n", cs_n, 1);
        pulse_cmd(start);
        for (int i = 0; i < 5; i++) begin
            if (convst_n != 1'b1) chk("R9", "convst in sleep", convst_n, 1);
            @(negedge clk);
        end
        chk("R9", "still asleep", shdn_n, 0);
        pulse_cmd(wake);
        chk("R10", "wake from sleep shdn_n", shdn_n, 1);
        chk("R10", "wake from sleep cs_n", cs_n, 1);
    endtask

    task automatic test_timeout;
        int k;
        pulse_cmd(start);
        k = 0;
        while (convst_n == 1'b0 && k < 100) begin
            k++;
            @(negedge clk);
        end
        k = 1;
        chk("R5", "timeout early", tmo_flag, 0);
        while (tmo_flag == 1'b0 && k < 300) begin
            @(negedge clk);
            k++;
        end
        chk("R5", "timeout sample", k, TMO + 1);
        chk("R5", "cs_n released", cs_n, 1);
        chk("R5", "convst_n released", convst_n, 1);
        chk("R5", "rd_n released", rd_n, 1);
        do_conversion(16'h5AA5, 4, 1'b0);
        chk("R5", "timeout sticky", tmo_flag, 1);
    endtask

    initial begin
        repeat (100000) @(posedge clk);
        n_bad++;
        $display("FAIL watchdog: actual=hung expected=finished");
        $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
        $finish;
    end

    initial begin
        repeat (3) @(posedge clk);
        @(negedge clk);
        test_reset();
        rst = 1'b0;
        @(negedge clk);
        test_reset();
        do_conversion(16'hA5C3, 6, 1'b0);
        do_conversion(16'h0F10, 12, 1'b0);
        test_nap();
        test_sleep();
        do_conversion(16'h7E81, 8, 1'b1);
        test_timeout();
        $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
        $finish;
    end
endmodule